// File: doc/BRIEF.md
# Passive JTAG Scan Monitor

This block listens to a JTAG port without driving it. It samples the five JTAG pins with the fast system clock, finds the edges of the test clock, and follows the TAP controller through its sixteen states. For every scan segment it collects the bits moved on the data-in line and the bits moved on the data-out line. It keeps them in two separate buffers. Each buffer is emptied and reported when the controller enters an Exit1 state. Every rising test-clock edge also produces a report of the state just entered.

All reports leave through one valid/ready stream. A report stays on the port, unchanged, until the consumer takes it with `rpt_ready`. There is one holding slot for each report kind. If the consumer stalls long enough for a second report of the same kind to arrive, the newer one replaces the older one. The test clock must run at one quarter of the system clock or slower. A consumer that keeps `rpt_ready` high then never loses a report.

Top module: `tap_scan_observer`

## Requirements
- R1: After reset the tracked state is Test-Logic-Reset (code 0) and `rpt_valid` is low.
- R2: Only a 0-to-1 (rising) or 1-to-0 (falling) change of the synchronized TCK counts as an edge. The first sample after reset is never an edge. TMS, TDI or TDO changes with TCK steady produce no report.
- R3: The state advances only on a rising edge, following the standard TMS tree. State codes: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR. Select-IR with TMS=1 returns to code 0, and Exit2 with TMS=0 goes back to Shift.
- R4: Every rising edge yields a report of kind 0 whose `rpt_state` is the new state, even when the state did not change.
- R5: On a rising edge in a Shift state, TDI is stored at bit index equal to the current count. On a rising edge in an Exit1 state, a kind 1 report is issued with the stored bits, the count, `rpt_state` set to that Exit1 code and `rpt_ir` high for the IR path. The buffer is then cleared. This report leaves before the state report of the same edge.
- R6: On a falling edge in a Shift state, TDO is stored in the same way. On a falling edge in an Exit1 state, a kind 2 report is issued with the same fields, and the buffer is cleared.
- R7: A buffer holds the first DEPTH (64) bits. Further bits only raise the count. A report whose segment was longer than DEPTH has `rpt_ovf` high.
- R8: TRST low forces Test-Logic-Reset and empties both buffers without issuing a report.
- R9: While `rpt_valid` is high and `rpt_ready` is low, every report field holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tck | input | 1 | Observed test clock |
| tms | input | 1 | Observed mode select |
| tdi | input | 1 | Observed data toward the device |
| tdo | input | 1 | Observed data from the device |
| trst_n | input | 1 | Observed test reset, active low |
| rpt_valid | output | 1 | Report available |
| rpt_ready | input | 1 | Consumer takes the report |
| rpt_kind | output | 2 | 0 state, 1 TDI segment, 2 TDO segment |
| rpt_state | output | 4 | New state, or the Exit1 code for a segment |
| rpt_ir | output | 1 | Segment belongs to the IR path |
| rpt_count | output | CNT_W | Bits seen in the segment |
| rpt_ovf | output | 1 | Segment exceeded DEPTH |
| rpt_bits | output | DEPTH | Captured bits, first bit at index 0 |

## Verification
The hardest case to reach is the one where the TDI segment report and the state report come from the same rising edge while the consumer is stalling. This case shows both the order of the two reports and the hold of the payload under back-pressure. The stimulus reaches it by dropping `rpt_ready` just before the test clock rises out of Exit1-DR. It then checks twice during the stall that the pending report does not move, and releases `rpt_ready` before the next falling edge. Overflow needs a shift segment longer than 64 bits. Test-reset coverage needs TRST pulled low in the middle of a shift, followed by a short segment whose count shows that the buffer was emptied.

// File: rtl/tapmon_pkg.sv
package tapmon_pkg;

  typedef enum logic [3:0] {
    TS_RESET   = 4'd0,  TS_IDLE    = 4'd1,
    TS_SEL_DR  = 4'd2,  TS_CAP_DR  = 4'd3,
    TS_SH_DR   = 4'd4,  TS_EX1_DR  = 4'd5,
    TS_PAU_DR  = 4'd6,  TS_EX2_DR  = 4'd7,
    TS_UPD_DR  = 4'd8,  TS_SEL_IR  = 4'd9,
    TS_CAP_IR  = 4'd10, TS_SH_IR   = 4'd11,
    TS_EX1_IR  = 4'd12, TS_PAU_IR  = 4'd13,
    TS_EX2_IR  = 4'd14, TS_UPD_IR  = 4'd15
  } tap_state_e;

  typedef enum logic [1:0] {
    RK_STATE = 2'd0,
    RK_TDI   = 2'd1,
    RK_TDO   = 2'd2
  } rpt_kind_e;

  function automatic tap_state_e tap_step(input tap_state_e s, input logic m);
    case (s)
      TS_RESET:  return m ? TS_RESET  : TS_IDLE;
      TS_IDLE:   return m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: return m ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: return m ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  return m ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: return m ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: return m ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: return m ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: return m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: return m ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: return m ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  return m ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: return m ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: return m ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: return m ? TS_UPD_IR : TS_SH_IR;
      default:   return m ? TS_SEL_DR : TS_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/tapmon_sync.sv
module tapmon_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] pins_o,
  output logic         rise_o,
  output logic         fall_o
);
  localparam int FILL_W = $clog2(STAGES + 2);

  logic [W-1:0]      stg [STAGES];
  logic              tck_q;
  logic [FILL_W-1:0] fill;
  logic              primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      tck_q <= 1'b0;
      fill  <= '0;
    end else begin
      stg[0] <= pins_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      tck_q <= stg[STAGES-1][0];
      if (!primed) fill <= fill + 1'b1;
    end
  end

  assign primed = (int'(fill) == STAGES + 1);
  assign pins_o = stg[STAGES-1];
  assign rise_o = primed &  pins_o[0] & ~tck_q;
  assign fall_o = primed & ~pins_o[0] &  tck_q;

  // one level change yields one edge pulse only
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  p_single_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/tapmon_tap.sv
module tapmon_tap
  import tapmon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trst_n_s,
  input  logic       rise,
  input  logic       tms_s,
  output tap_state_e state_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state_o <= TS_RESET;
    else if (!trst_n_s) state_o <= TS_RESET;
    else if (rise)      state_o <= tap_step(state_o, tms_s);
  end

  p_trst_forces_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !trst_n_s |=> state_o == TS_RESET);
  p_hold_without_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trst_n_s && !rise) |=> $stable(state_o));
  p_shift_leaves_to_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trst_n_s && rise && tms_s && state_o == TS_SH_DR) |=> state_o == TS_EX1_DR);

endmodule

// File: rtl/tapmon_seg.sv
module tapmon_seg #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             bit_i,
  input  logic             flush,
  output logic [DEPTH-1:0] bits_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_o <= '0;
      cnt_o  <= '0;
      ovf_o  <= 1'b0;
    end else if (clear || flush) begin
      bits_o <= '0;
      cnt_o  <= '0;
      ovf_o  <= 1'b0;
    end else if (take) begin
      if (cnt_o < CNT_W'(DEPTH)) bits_o[cnt_o[IDX_W-1:0]] <= bit_i;
      else                       ovf_o <= 1'b1;
      if (cnt_o != '1) cnt_o <= cnt_o + 1'b1;
    end
  end

  p_ovf_needs_long_segment_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> cnt_o > CNT_W'(DEPTH));
  p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_o == '0) && !ovf_o);

endmodule

// File: rtl/tap_scan_observer.sv
module tap_scan_observer
  import tapmon_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tck,
  input  logic             tms,
  input  logic             tdi,
  input  logic             tdo,
  input  logic             trst_n,
  output logic             rpt_valid,
  input  logic             rpt_ready,
  output logic [1:0]       rpt_kind,
  output logic [3:0]       rpt_state,
  output logic             rpt_ir,
  output logic [CNT_W-1:0] rpt_count,
  output logic             rpt_ovf,
  output logic [DEPTH-1:0] rpt_bits
);
  localparam int NSEG = 2;   // index 0: TDI buffer, index 1: TDO buffer

  logic [4:0] pins_s;
  logic       rise, fall;
  tap_state_e st;

  tapmon_sync #(.W(5), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i({trst_n, tdo, tdi, tms, tck}),
    .pins_o(pins_s), .rise_o(rise), .fall_o(fall));

  tapmon_tap u_tap (
    .clk(clk), .rst_n(rst_n), .trst_n_s(pins_s[4]), .rise(rise),
    .tms_s(pins_s[1]), .state_o(st));

  logic in_shift, in_exit1;
  assign in_shift = (st == TS_SH_DR)  || (st == TS_SH_IR);
  assign in_exit1 = (st == TS_EX1_DR) || (st == TS_EX1_IR);

  logic [NSEG-1:0]  seg_edge, seg_bit, flush, seg_ovf;
  logic [DEPTH-1:0] seg_bits [NSEG];
  logic [CNT_W-1:0] seg_cnt  [NSEG];

  assign seg_edge = {fall, rise};
  assign seg_bit  = {pins_s[3], pins_s[2]};

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign flush[g] = seg_edge[g] & in_exit1;
    tapmon_seg #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_seg (
      .clk(clk), .rst_n(rst_n), .clear(~pins_s[4]),
      .take(seg_edge[g] & in_shift), .bit_i(seg_bit[g]), .flush(flush[g]),
      .bits_o(seg_bits[g]), .cnt_o(seg_cnt[g]), .ovf_o(seg_ovf[g]));
  end

  // holding slots, one per report kind
  logic [NSEG-1:0]  sl_full, sl_ovf, sl_ir, tk_seg;
  logic [DEPTH-1:0] sl_bits [NSEG];
  logic [CNT_W-1:0] sl_cnt  [NSEG];
  logic [3:0]       sl_code [NSEG];
  logic             st_full, tk_st, rise_d, can_load;
  logic [3:0]       st_code;

  assign can_load  = !rpt_valid || rpt_ready;
  assign tk_seg[0] = can_load & sl_full[0];
  assign tk_seg[1] = can_load & ~sl_full[0] & sl_full[1];
  assign tk_st     = can_load & ~(|sl_full) & st_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sl_full <= '0; sl_ovf <= '0; sl_ir <= '0;
      for (int g = 0; g < NSEG; g++) begin
        sl_bits[g] <= '0; sl_cnt[g] <= '0; sl_code[g] <= '0;
      end
      st_full <= 1'b0; st_code <= '0; rise_d <= 1'b0;
    end else begin
      rise_d <= rise;
      for (int g = 0; g < NSEG; g++) begin
        if (flush[g]) begin
          sl_full[g] <= 1'b1;
          sl_bits[g] <= seg_bits[g];
          sl_cnt[g]  <= seg_cnt[g];
          sl_ovf[g]  <= seg_ovf[g];
          sl_ir[g]   <= (st == TS_EX1_IR);
          sl_code[g] <= st;
        end else if (tk_seg[g]) begin
          sl_full[g] <= 1'b0;
        end
      end
      if (rise_d) begin
        st_full <= 1'b1;
        st_code <= st;
      end else if (tk_st) begin
        st_full <= 1'b0;
      end
    end
  end

  // output register: loaded only when empty or being taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_valid <= 1'b0; rpt_kind <= RK_STATE; rpt_state <= '0; rpt_ir <= 1'b0;
      rpt_count <= '0;   rpt_ovf  <= 1'b0;     rpt_bits  <= '0;
    end else if (can_load) begin
      rpt_valid <= (|sl_full) | st_full;
      if (tk_st) begin
        rpt_kind <= RK_STATE; rpt_state <= st_code; rpt_ir <= 1'b0;
        rpt_count <= '0;      rpt_ovf   <= 1'b0;    rpt_bits <= '0;
      end else begin
        for (int g = 0; g < NSEG; g++) begin
          if (tk_seg[g]) begin
            rpt_kind  <= (g == 0) ? RK_TDI : RK_TDO;
            rpt_state <= sl_code[g]; rpt_ir <= sl_ir[g];
            rpt_count <= sl_cnt[g];  rpt_ovf <= sl_ovf[g];
            rpt_bits  <= sl_bits[g];
          end
        end
      end
    end
  end

  p_hold_under_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_ready) |=> rpt_valid && $stable(rpt_kind) && $stable(rpt_state)
      && $stable(rpt_count) && $stable(rpt_bits));
  p_tdi_before_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (can_load && sl_full[0] && st_full) |=> rpt_kind == RK_TDI);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rpt_valid) |-> $past(|sl_full || st_full));

endmodule

// File: tb/tap_scan_observer_tb_top.sv
module tap_scan_observer_tb_top;
  localparam int DEPTH = 64;
  localparam int CNT_W = 16;
  localparam int QN    = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tck = 1'b1, tms = 1'b1, tdi = 1'b0, tdo = 1'b0, trst_n = 1'b1;
  logic rpt_ready = 1'b1;
  logic rpt_valid, rpt_ir, rpt_ovf;
  logic [1:0] rpt_kind;
  logic [3:0] rpt_state;
  logic [CNT_W-1:0] rpt_count;
  logic [DEPTH-1:0] rpt_bits;

  always #2 clk = ~clk;

  tap_scan_observer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
    .trst_n(trst_n), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
    .rpt_kind(rpt_kind), .rpt_state(rpt_state), .rpt_ir(rpt_ir),
    .rpt_count(rpt_count), .rpt_ovf(rpt_ovf), .rpt_bits(rpt_bits));

  int checks = 0, errors = 0;

  // captured reports
  int act_n = 0;
  logic [1:0] a_kind [QN]; logic [3:0] a_state [QN]; logic a_ir [QN];
  logic [CNT_W-1:0] a_cnt [QN]; logic a_ovf [QN]; logic [DEPTH-1:0] a_bits [QN];
  // expected reports
  int exp_n = 0, cmp_ptr = 0;
  logic [1:0] e_kind [QN]; logic [3:0] e_state [QN]; logic e_ir [QN];
  logic [CNT_W-1:0] e_cnt [QN]; logic e_ovf [QN]; logic [DEPTH-1:0] e_bits [QN];
  string e_tag [QN];

  always @(negedge clk) begin
    if (rst_n && rpt_valid && rpt_ready && act_n < QN) begin
      a_kind[act_n] = rpt_kind; a_state[act_n] = rpt_state; a_ir[act_n] = rpt_ir;
      a_cnt[act_n] = rpt_count; a_ovf[act_n] = rpt_ovf; a_bits[act_n] = rpt_bits;
      act_n++;
    end
  end

  // independent reference of the TAP tree and buffers
  int m_st = 0;
  logic [DEPTH-1:0] m_bits [2];
  int m_cnt [2];
  bit m_ovf [2];

  function automatic int nxt(input int s, input bit m);
    case (s)
      0: return m ? 0 : 1;    1: return m ? 2 : 1;
      2: return m ? 9 : 3;    3: return m ? 5 : 4;
      4: return m ? 5 : 4;    5: return m ? 8 : 6;
      6: return m ? 7 : 6;    7: return m ? 8 : 4;
      8: return m ? 2 : 1;    9: return m ? 0 : 10;
      10: return m ? 12 : 11; 11: return m ? 12 : 11;
      12: return m ? 15 : 13; 13: return m ? 14 : 13;
      14: return m ? 15 : 11; default: return m ? 2 : 1;
    endcase
  endfunction

  task automatic push(input int kind, input int st, input int b, input string tag);
    e_kind[exp_n] = 2'(kind); e_state[exp_n] = 4'(st);
    if (kind == 0) begin
      e_ir[exp_n] = 1'b0; e_cnt[exp_n] = '0; e_ovf[exp_n] = 1'b0; e_bits[exp_n] = '0;
      e_tag[exp_n] = tag;
    end else begin
      e_ir[exp_n] = (st == 12); e_cnt[exp_n] = CNT_W'(m_cnt[b]);
      e_ovf[exp_n] = m_ovf[b]; e_bits[exp_n] = m_bits[b];
      e_tag[exp_n] = m_ovf[b] ? "R7" : tag;
      m_bits[b] = '0; m_cnt[b] = 0; m_ovf[b] = 1'b0;
    end
    exp_n++;
  endtask

  task automatic add_bit(input int b, input bit v);
    if (m_cnt[b] < DEPTH) m_bits[b][m_cnt[b]] = v; else m_ovf[b] = 1'b1;
    m_cnt[b]++;
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic tick(input bit ms, input bit di, input bit dd);
    tms = ms; tdi = di; tdo = dd;
    step(4);
    tck = 1'b1;
    if (m_st == 4 || m_st == 11) add_bit(0, di);
    else if (m_st == 5 || m_st == 12) push(1, m_st, 0, "R5");
    m_st = nxt(m_st, ms);
    push(0, m_st, 0, "R4");
    step(4);
    tck = 1'b0;
    if (m_st == 4 || m_st == 11) add_bit(1, dd);
    else if (m_st == 5 || m_st == 12) push(2, m_st, 1, "R6");
    step(4);
  endtask

  task automatic check(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic verify(input string tag);
    step(12);
    for (int i = cmp_ptr; i < exp_n; i++) begin
      if (i >= act_n) begin
        check(1'b0, e_tag[i], $sformatf("report %0d missing, expected kind %0d state %0d",
              i, e_kind[i], e_state[i]));
      end else begin
        check(a_kind[i] == e_kind[i] && a_state[i] == e_state[i] && a_ir[i] == e_ir[i]
              && a_cnt[i] == e_cnt[i] && a_ovf[i] == e_ovf[i] && a_bits[i] == e_bits[i],
              e_tag[i],
              $sformatf("report %0d actual kind %0d st %0d ir %0d cnt %0d ovf %0d bits %h, expected kind %0d st %0d ir %0d cnt %0d ovf %0d bits %h",
                i, a_kind[i], a_state[i], a_ir[i], a_cnt[i], a_ovf[i], a_bits[i],
                e_kind[i], e_state[i], e_ir[i], e_cnt[i], e_ovf[i], e_bits[i]));
      end
    end
    check(act_n == exp_n, tag, $sformatf("report count actual %0d expected %0d", act_n, exp_n));
    cmp_ptr = exp_n;
    if (act_n > exp_n) cmp_ptr = act_n;
    exp_n = cmp_ptr;
  endtask

  // R1, R2: reset state, first sample and steady TCK
  task automatic t_reset_quiet();
    step(3);
    check(rpt_valid == 1'b0, "R1", $sformatf("rpt_valid in reset actual %0b expected 0", rpt_valid));
    rst_n = 1'b1;
    step(8);
    check(rpt_valid == 1'b0, "R1", $sformatf("rpt_valid after reset actual %0b expected 0", rpt_valid));
    tms = 1'b0; tdi = 1'b1; tdo = 1'b1; step(6);
    tms = 1'b1; tdi = 1'b0; tdo = 1'b0; step(6);
    tck = 1'b0; step(6);  // falling edge in Test-Logic-Reset: nothing
    verify("R2");
    tick(1, 0, 0);        // R4: unchanged state still reported
    tick(0, 0, 0);        // R3: reset -> idle
    verify("R3");
  endtask

  task automatic t_dr_scan();
    tick(1, 0, 0); tick(0, 0, 0); tick(0, 1, 0);
    tick(0, 1, 1); tick(0, 0, 1); tick(0, 1, 0); tick(0, 1, 1);
    tick(0, 0, 0); tick(0, 0, 1); tick(1, 1, 1);
    tick(1, 0, 0); tick(0, 0, 0);
    verify("R5");
  endtask

  // R3: pause loop and Exit2 back to Shift on the IR path
  task automatic t_ir_pause();
    tick(1, 0, 0); tick(1, 0, 0); tick(0, 0, 0); tick(0, 1, 1);
    tick(0, 0, 1); tick(0, 1, 0); tick(1, 1, 0);
    tick(0, 0, 0); tick(0, 0, 0); tick(1, 0, 0); tick(0, 0, 0);
    tick(0, 0, 1); tick(1, 1, 1);
    tick(1, 0, 0); tick(0, 0, 0);
    verify("R6");
  endtask

  task automatic t_select_ir_reset();
    tick(1, 0, 0); tick(1, 0, 0); tick(1, 0, 0); tick(1, 0, 0);
    tick(0, 0, 0); tick(0, 0, 0);
    verify("R3");
  endtask

  task automatic t_overflow();
    tick(1, 0, 0); tick(0, 0, 0);
    for (int i = 0; i < 70; i++) tick(i == 69, (i % 3) == 0, (i % 5) == 1);
    tick(1, 0, 0); tick(0, 0, 0);
    verify("R7");
  endtask

  task automatic t_trst();
    tick(1, 0, 0); tick(0, 0, 0);
    for (int i = 0; i < 5; i++) tick(0, 1, 1);
    trst_n = 1'b0; step(8);
    m_st = 0; m_bits[0] = '0; m_bits[1] = '0;
    m_cnt[0] = 0; m_cnt[1] = 0; m_ovf[0] = 1'b0; m_ovf[1] = 1'b0;
    trst_n = 1'b1; step(8);
    tick(0, 0, 0); tick(1, 0, 0); tick(0, 0, 0);
    tick(0, 1, 0); tick(0, 0, 1); tick(1, 1, 1);
    tick(1, 0, 0); tick(0, 0, 0);
    verify("R8");
  endtask

  // R9 and R5 ordering: stall across the edge leaving Exit1-DR
  task automatic t_stall();
    logic [1:0] k0; logic [CNT_W-1:0] c0;
    tick(1, 0, 0); tick(0, 0, 0); tick(0, 1, 1); tick(0, 0, 1); tick(1, 1, 0);
    tms = 1'b1; tdi = 1'b0; tdo = 1'b0;
    step(4);
    rpt_ready = 1'b0;
    tck = 1'b1;
    push(1, m_st, 0, "R5"); m_st = nxt(m_st, 1'b1); push(0, m_st, 0, "R4");
    step(4);
    @(negedge clk); k0 = rpt_kind; c0 = rpt_count;
    check(rpt_valid == 1'b1, "R9", $sformatf("valid during stall actual %0b expected 1", rpt_valid));
    @(negedge clk);
    check(rpt_kind == k0 && rpt_count == c0 && rpt_valid, "R9",
          $sformatf("stalled kind/count actual %0d/%0d expected %0d/%0d", rpt_kind, rpt_count, k0, c0));
    check(k0 == 2'd1, "R5", $sformatf("first pending kind actual %0d expected 1", k0));
    step(1);
    rpt_ready = 1'b1;
    step(2);
    tck = 1'b0;
    step(4);
    tick(0, 0, 0);
    verify("R9");
  endtask

  initial begin
    m_bits[0] = '0; m_bits[1] = '0; m_cnt[0] = 0; m_cnt[1] = 0;
    m_ovf[0] = 1'b0; m_ovf[1] = 1'b0;
    t_reset_quiet();
    t_dr_scan();
    t_ir_pause();
    t_select_ir_reset();
    t_overflow();
    t_trst();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule